// File: doc/BRIEF.md
# Pixel-Doubling Character Display Controller

This block drives a VGA-style monitor from a text-mode frame buffer. The logical picture is a monochrome grid of 8x8-pixel character cells: by default 40 columns by 25 rows, which gives a 320x200 frame. Every logical pixel is drawn as a 2x2 square, so the visible area is 640x400 output pixels. With a 100 MHz system clock and a divide-by-4 pixel enable, a line is 800 pixel periods and a frame is 525 lines, which gives a refresh rate close to 60 Hz.

The controller reads character codes from an external video RAM and glyph rows from an external font ROM. Both are plain synchronous-read memories with one clock of latency. They have no handshake, because the controller always takes the data at a fixed phase of each 16-pixel cell. The code and glyph byte for a cell are fetched during the cell before it, and for the first cell of a line during the tail of horizontal blanking. The glyph byte is therefore complete before the cell's first pixel. The pixel for each position depends only on memory data captured within its own fetch window, so the host may write the video RAM at any time without tearing inside a cell.

Bit 7 of a character code displays the glyph inverted. A host-driven blank input darkens the picture, while sync and data-enable keep running unchanged. A retrace status output tells the host when the beam is in vertical blanking. The line length must be a multiple of 16 pixel periods.

Top module: `vga_dbl_ctrl`

## Requirements
- R1: While reset is high and on the first edge after it, hsync_n_o and vsync_n_o are 1, and de_o, video_o and vretrace_o are 0. After reset the scan restarts at position (0,0).
- R2: The position advances once every DIV clocks. Each line has H_TOTAL positions. de_o is 1 exactly for columns below COLS*16 on active lines. hsync_n_o is 0 exactly for columns from COLS*16+H_FP up to, but not including, COLS*16+H_FP+H_SW.
- R3: Each frame has V_TOTAL lines. vsync_n_o is 0 exactly on lines from ROWS*16+V_FP up to, but not including, ROWS*16+V_FP+V_SW.
- R4: vretrace_o is 1 exactly on lines at or beyond ROWS*16, and 0 on every active line.
- R5: Each glyph bit covers two adjacent output pixels. The glyph's bit 7 is shown leftmost in the cell.
- R6: Each glyph row covers two adjacent output lines. Output line v uses glyph row (v/2) mod 8.
- R7: The cell at output position (h,v) reads video RAM address (v/16)*COLS + h/16. The font ROM address is formed as bits [9:3] = code[6:0] and bits [2:0] = glyph row. The video RAM address never reaches COLS*ROWS.
- R8: If bit 7 of a character code is 1, every glyph bit of that cell is inverted before display.
- R9: video_o is 0 at every position outside the active area.
- R10: While blank_i is high, video_o is 0 from the next position on. Sync, de_o and vretrace_o are not affected by blank_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| blank_i | input | 1 | Host screen-blank request |
| vram_addr_o | output | AW (10) | Video RAM read address |
| vram_data_i | input | 8 | Character code, one clock after address |
| font_addr_o | output | 10 | Font ROM read address {code[6:0], row} |
| font_data_i | input | 8 | Glyph row, one clock after address |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Active-area enable |
| video_o | output | 1 | Monochrome pixel |
| vretrace_o | output | 1 | High during vertical blanking |

## Verification
The hardest case to reach is the prefetch of each line's first cell. That fetch happens in the tail of the previous line's blanking. At the end of the frame it must wrap from the last line back to line 0, so any error there shows up only on the first cell of a line, or only on the first line of a frame. The bench therefore runs whole frames at reduced geometry and compares every position against a model. Between frames it rewrites the video RAM and changes blank during vertical retrace, so that each new frame depends on a correct wrap-around fetch. A reset in the middle of a frame then checks that the scan restarts cleanly.

// File: rtl/vga_dbl_pkg.sv
package vga_dbl_pkg;
  localparam int CELL_OUT = 16;
  localparam int FONT_AW  = 10;

  typedef struct packed {
    logic hsync_n;
    logic vsync_n;
    logic de;
    logic vretrace;
  } vga_dbl_sync_t;

  localparam vga_dbl_sync_t SYNC_IDLE = '{hsync_n: 1'b1, vsync_n: 1'b1, de: 1'b0, vretrace: 1'b0};
endpackage

// File: rtl/vga_dbl_timing.sv
module vga_dbl_timing
  import vga_dbl_pkg::*;
#(
  parameter int H_ACT   = 640,
  parameter int H_FP    = 16,
  parameter int H_SW    = 96,
  parameter int H_TOTAL = 800,
  parameter int V_ACT   = 400,
  parameter int V_FP    = 12,
  parameter int V_SW    = 2,
  parameter int V_TOTAL = 525,
  parameter int DIV     = 4,
  parameter int HW      = 10,
  parameter int VW      = 10
) (
  input  logic          clk_i,
  input  logic          rst_i,
  output logic          pix_en_o,
  output logic [HW-1:0] hcnt_o,
  output logic [VW-1:0] vcnt_o,
  output vga_dbl_sync_t sync_o
);
  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  vga_dbl_sync_t sync_q;

  generate
    if (DIV > 1) begin : g_div
      localparam int DW = $clog2(DIV);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) div_q <= '0;
        else if (div_q == DW'(DIV - 1)) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end
      assign pix_en_o = (div_q == DW'(DIV - 1));
    end else begin : g_nodiv
      assign pix_en_o = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      h_q <= '0;
      v_q <= '0;
    end else if (pix_en_o) begin
      if (h_q == HW'(H_TOTAL - 1)) begin
        h_q <= '0;
        v_q <= (v_q == VW'(V_TOTAL - 1)) ? '0 : v_q + 1'b1;
      end else begin
        h_q <= h_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= SYNC_IDLE;
    end else if (pix_en_o) begin
      sync_q.hsync_n  <= !((int'(h_q) >= H_ACT + H_FP) && (int'(h_q) < H_ACT + H_FP + H_SW));
      sync_q.vsync_n  <= !((int'(v_q) >= V_ACT + V_FP) && (int'(v_q) < V_ACT + V_FP + V_SW));
      sync_q.de       <= (int'(h_q) < H_ACT) && (int'(v_q) < V_ACT);
      sync_q.vretrace <= (int'(v_q) >= V_ACT);
    end
  end

  assign hcnt_o = h_q;
  assign vcnt_o = v_q;
  assign sync_o = sync_q;

  assert_hcnt_bound_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(h_q) < H_TOTAL);
  assert_hsync_outside_picture_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !sync_q.hsync_n |-> !sync_q.de);
  assert_vsync_inside_retrace_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    !sync_q.vsync_n |-> sync_q.vretrace);
  assert_retrace_dark_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    sync_q.vretrace |-> !sync_q.de);
endmodule

// File: rtl/vga_dbl_fetch.sv
module vga_dbl_fetch
  import vga_dbl_pkg::*;
#(
  parameter int COLS    = 40,
  parameter int ROWS    = 25,
  parameter int H_ACT   = 640,
  parameter int H_TOTAL = 800,
  parameter int V_ACT   = 400,
  parameter int V_TOTAL = 525,
  parameter int HW      = 10,
  parameter int VW      = 10,
  parameter int AW      = 10
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               pix_en_i,
  input  logic [HW-1:0]      hcnt_i,
  input  logic [VW-1:0]      vcnt_i,
  output logic [AW-1:0]      vram_addr_o,
  input  logic [7:0]         vram_data_i,
  output logic [FONT_AW-1:0] font_addr_o,
  input  logic [7:0]         font_data_i,
  output logic [7:0]         glyph_o
);
  int       lead_col, lead_line;
  logic     lead_ok;
  logic [3:0] phase;
  logic [AW-1:0]      vram_addr_q;
  logic [FONT_AW-1:0] font_addr_q;
  logic [2:0] row_q;
  logic       inv_q;
  logic [7:0] glyph_q;

  assign phase = hcnt_i[3:0];

  always_comb begin
    lead_col  = 0;
    lead_line = 0;
    lead_ok   = 1'b0;
    if (int'(hcnt_i) >= H_TOTAL - CELL_OUT) begin
      lead_line = (int'(vcnt_i) == V_TOTAL - 1) ? 0 : int'(vcnt_i) + 1;
      lead_ok   = lead_line < V_ACT;
    end else if (int'(hcnt_i) < H_ACT - CELL_OUT) begin
      lead_col  = int'(hcnt_i) / CELL_OUT + 1;
      lead_line = int'(vcnt_i);
      lead_ok   = lead_line < V_ACT;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vram_addr_q <= '0;
      font_addr_q <= '0;
      row_q       <= '0;
      inv_q       <= 1'b0;
      glyph_q     <= '0;
    end else if (pix_en_i && lead_ok) begin
      case (phase)
        4'd0: begin
          vram_addr_q <= AW'((lead_line / CELL_OUT) * COLS + lead_col);
          row_q       <= 3'((lead_line / 2) % 8);
        end
        4'd4: begin
          inv_q       <= vram_data_i[7];
          font_addr_q <= {vram_data_i[6:0], row_q};
        end
        4'd8: glyph_q <= font_data_i ^ {8{inv_q}};
        default: ;
      endcase
    end
  end

  assign vram_addr_o = vram_addr_q;
  assign font_addr_o = font_addr_q;
  assign glyph_o     = glyph_q;

  assert_vram_addr_range_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(vram_addr_q) < COLS * ROWS);
  assert_font_addr_paced_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !pix_en_i |=> $stable(font_addr_q));
endmodule

// File: rtl/vga_dbl_shifter.sv
module vga_dbl_shifter #(
  parameter int H_ACT = 640,
  parameter int V_ACT = 400,
  parameter int HW    = 10,
  parameter int VW    = 10
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          pix_en_i,
  input  logic [HW-1:0] hcnt_i,
  input  logic [VW-1:0] vcnt_i,
  input  logic [7:0]    glyph_i,
  input  logic          blank_i,
  output logic          video_o
);
  logic [7:0] cell_q;
  logic       video_q;
  logic       active;

  assign active = (int'(hcnt_i) < H_ACT) && (int'(vcnt_i) < V_ACT);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cell_q  <= '0;
      video_q <= 1'b0;
    end else if (pix_en_i) begin
      if (hcnt_i[3:0] == 4'hF) cell_q <= glyph_i;
      video_q <= active && !blank_i && cell_q[~hcnt_i[3:1]];
    end
  end

  assign video_o = video_q;

  assert_blank_darkens_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (pix_en_i && blank_i) |=> !video_q);
  assert_dark_outside_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (pix_en_i && !active) |=> !video_q);
endmodule

// File: rtl/vga_dbl_ctrl.sv
module vga_dbl_ctrl
  import vga_dbl_pkg::*;
#(
  parameter int COLS = 40,
  parameter int ROWS = 25,
  parameter int H_FP = 16,
  parameter int H_SW = 96,
  parameter int H_BP = 48,
  parameter int V_FP = 12,
  parameter int V_SW = 2,
  parameter int V_BP = 111,
  parameter int DIV  = 4,
  parameter int AW   = $clog2(COLS * ROWS)
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               blank_i,
  output logic [AW-1:0]      vram_addr_o,
  input  logic [7:0]         vram_data_i,
  output logic [FONT_AW-1:0] font_addr_o,
  input  logic [7:0]         font_data_i,
  output logic               hsync_n_o,
  output logic               vsync_n_o,
  output logic               de_o,
  output logic               video_o,
  output logic               vretrace_o
);
  localparam int H_ACT   = COLS * CELL_OUT;
  localparam int V_ACT   = ROWS * CELL_OUT;
  localparam int H_TOTAL = H_ACT + H_FP + H_SW + H_BP;
  localparam int V_TOTAL = V_ACT + V_FP + V_SW + V_BP;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);

  logic          pix_en;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  vga_dbl_sync_t sync;
  logic [7:0]    glyph;

  vga_dbl_timing #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_TOTAL(H_TOTAL),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_TOTAL(V_TOTAL),
    .DIV(DIV), .HW(HW), .VW(VW)
  ) u_timing (
    .clk_i(clk_i), .rst_i(rst_i), .pix_en_o(pix_en),
    .hcnt_o(hcnt), .vcnt_o(vcnt), .sync_o(sync)
  );

  vga_dbl_fetch #(
    .COLS(COLS), .ROWS(ROWS), .H_ACT(H_ACT), .H_TOTAL(H_TOTAL),
    .V_ACT(V_ACT), .V_TOTAL(V_TOTAL), .HW(HW), .VW(VW), .AW(AW)
  ) u_fetch (
    .clk_i(clk_i), .rst_i(rst_i), .pix_en_i(pix_en),
    .hcnt_i(hcnt), .vcnt_i(vcnt),
    .vram_addr_o(vram_addr_o), .vram_data_i(vram_data_i),
    .font_addr_o(font_addr_o), .font_data_i(font_data_i),
    .glyph_o(glyph)
  );

  vga_dbl_shifter #(
    .H_ACT(H_ACT), .V_ACT(V_ACT), .HW(HW), .VW(VW)
  ) u_shifter (
    .clk_i(clk_i), .rst_i(rst_i), .pix_en_i(pix_en),
    .hcnt_i(hcnt), .vcnt_i(vcnt), .glyph_i(glyph),
    .blank_i(blank_i), .video_o(video_o)
  );

  assign hsync_n_o  = sync.hsync_n;
  assign vsync_n_o  = sync.vsync_n;
  assign de_o       = sync.de;
  assign vretrace_o = sync.vretrace;

  assert_video_in_picture_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    video_o |-> de_o);
  assert_reset_idle_R1: assert property (@(posedge clk_i)
    rst_i |=> (hsync_n_o && vsync_n_o && !de_o && !video_o && !vretrace_o));
endmodule

// File: tb/vga_dbl_ctrl_bench.sv
module vga_dbl_ctrl_bench;
  localparam int COLS = 4, ROWS = 2;
  localparam int H_FP = 16, H_SW = 16, H_BP = 16;
  localparam int V_FP = 2, V_SW = 2, V_BP = 4;
  localparam int DIV = 2;
  localparam int H_ACT = COLS * 16, V_ACT = ROWS * 16;
  localparam int H_TOTAL = H_ACT + H_FP + H_SW + H_BP;
  localparam int V_TOTAL = V_ACT + V_FP + V_SW + V_BP;
  localparam int NCELL = COLS * ROWS;
  localparam int AW = $clog2(NCELL);
  localparam int NTAB = 4;
  // {pattern[1:0], blank, picture expected to have lit pixels}
  localparam logic [3:0] TAB [NTAB] = '{4'b0001, 4'b0101, 4'b1010, 4'b1001};

  logic clk = 1'b0;
  logic rst, blank;
  logic [AW-1:0] vram_addr;
  logic [7:0] vram_q, font_q;
  logic [9:0] font_addr;
  logic hs_n, vs_n, de, vid, vr;
  logic [7:0] vram [NCELL];
  int checks = 0, fails = 0;
  int e_h, e_v, e_vr, e_de, e_vid, e_addr, lit;
  string e_msg;

  always #5 clk = ~clk;

  vga_dbl_ctrl #(
    .COLS(COLS), .ROWS(ROWS), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP), .DIV(DIV)
  ) u_vga_dbl_ctrl (
    .clk_i(clk), .rst_i(rst), .blank_i(blank),
    .vram_addr_o(vram_addr), .vram_data_i(vram_q),
    .font_addr_o(font_addr), .font_data_i(font_q),
    .hsync_n_o(hs_n), .vsync_n_o(vs_n), .de_o(de), .video_o(vid), .vretrace_o(vr)
  );

  function automatic logic [7:0] glyph(input logic [6:0] c, input logic [2:0] s);
    return {c[3:0], s, c[4]} ^ {s, c[6:2]} ^ 8'h35;
  endfunction

  function automatic logic [7:0] pat_val(input int p, input int i);
    case (p)
      0: return 8'(i * 17 + 3);
      1: return 8'(8'h80 | (i * 5 + 2));
      2: return (i % 2 == 1) ? 8'(8'h80 | (i * 9)) : 8'(i * 9 + 1);
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    vram_q <= vram[vram_addr];
    font_q <= glyph(font_addr[9:3], font_addr[2:0]);
  end

  function automatic logic exp_pix(input int h, input int v);
    logic [7:0] code, f;
    if (h >= H_ACT || v >= V_ACT || blank) return 1'b0;
    code = vram[(v / 16) * COLS + h / 16];
    f = glyph(code[6:0], 3'((v / 2) % 8));
    if (code[7]) f = ~f;
    return f[7 - ((h / 2) % 8)];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_frame(input bit chk_vid, input int nxt_pat, input bit nxt_blank);
    e_h = 0; e_v = 0; e_vr = 0; e_de = 0; e_vid = 0; e_addr = 0; lit = 0;
    for (int v = 0; v < V_TOTAL; v++) begin
      for (int h = 0; h < H_TOTAL; h++) begin
        logic xh, xv, xde, xvid;
        repeat (DIV) @(posedge clk);
        @(negedge clk);
        xh   = !(h >= H_ACT + H_FP && h < H_ACT + H_FP + H_SW);
        xv   = !(v >= V_ACT + V_FP && v < V_ACT + V_FP + V_SW);
        xde  = (h < H_ACT) && (v < V_ACT);
        xvid = exp_pix(h, v);
        if (hs_n !== xh) e_h++;
        if (vs_n !== xv) e_v++;
        if (de !== xde) e_de++;
        if (vr !== (v >= V_ACT)) e_vr++;
        if (int'(vram_addr) >= NCELL) e_addr++;
        if (chk_vid && vid !== xvid) begin
          if (e_vid == 0) e_msg = $sformatf("h=%0d v=%0d got %0b want %0b", h, v, vid, xvid);
          e_vid++;
        end
        if (vid === 1'b1) lit++;
        if (v == V_ACT && h == 0) begin
          for (int i = 0; i < NCELL; i++) vram[i] = pat_val(nxt_pat, i);
          blank = nxt_blank;
        end
      end
    end
    check(e_h == 0 && e_de == 0, "R2 hsync/de mismatches", e_h + e_de, 0);
    check(e_v == 0, "R3 vsync mismatches", e_v, 0);
    check(e_vr == 0, "R4 vretrace mismatches", e_vr, 0);
    check(e_addr == 0, "R7 vram address range", e_addr, 0);
    if (chk_vid) begin
      if (e_vid != 0) $display("first video mismatch %s", e_msg);
      check(e_vid == 0, "R5 R6 R7 R8 R9 R10 video mismatches", e_vid, 0);
    end
  endtask

  task automatic check_idle(input string when);
    check(hs_n === 1'b1 && vs_n === 1'b1, {"R1 syncs idle ", when}, {hs_n, vs_n}, 3);
    check(de === 1'b0 && vid === 1'b0 && vr === 1'b0, {"R1 de/video/retrace low ", when},
          {de, vid, vr}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    blank = 1'b0;
    for (int i = 0; i < NCELL; i++) vram[i] = 8'h00;
    repeat (4) @(negedge clk);
    check_idle("at start");
    rst = 1'b0;
    // warm-up frame: first line of this frame has no prefetched first cell
    run_frame(1'b0, int'(TAB[0][3:2]), TAB[0][1]);
    for (int i = 0; i < NTAB; i++) begin
      int nx;
      nx = (i + 1) % NTAB;
      run_frame(1'b1, int'(TAB[nx][3:2]), TAB[nx][1]);
      // R10: blank frames have no lit pixel, the others do
      check((lit != 0) == TAB[i][0], "R10 lit pixels present as tabled", lit, int'(TAB[i][0]));
    end
    // mid-frame reset
    repeat (DIV * (H_TOTAL * 3 + 21)) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_idle("after mid-frame reset");
    repeat (2) @(negedge clk);
    check_idle("held in reset");
    rst = 1'b0;
    run_frame(1'b0, 0, 1'b0);
    run_frame(1'b1, 0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule